// File: doc/BRIEF.md
# Digital I/O Card Bus Decoder with Shared Edge Interrupt

This block is the host-side control logic of an 8-bit port-mapped digital I/O card. The card takes up a 16-byte address window. Each host byte access, a read strobe or a write strobe with a 4-bit offset, is decoded into a chip select for one of two parallel-port groups or for an interval timer, together with a 2-bit register offset. The groups and the timer are outside this block. Written data goes straight from the host bus to them, because no control register here uses the value written. Read data comes back through `ext_rdata`.

Three control offsets change state depending only on the kind of access. A write to 0xB enables interrupt generation and a read of 0xB disables it. A write to 0xD switches the low four offsets from the first port group to the timer, and a read of 0xD switches them back. A write to 0xF clears any pending interrupt. Two external lines, bit 3 of port C in each group, are synchronised. A rising edge on either line, seen while interrupts are enabled, sets a sticky pending flag. These flags drive one active-high request line.

Top module: `dio_bus_ctrl`

## Requirements
- R1: With timer mode off, offsets 0x0–0x3 select group 0 (`grp_cs[0]`) and offsets 0x4–0x7 select group 1 (`grp_cs[1]`), and `reg_ofs` equals `addr[1:0]`. A write selects any of the four offsets. A read selects only offsets 0–2 of a group. At most one select is high at a time.
- R2: A read of a group's control slot (offset 3 or 7) asserts no select and returns 0xFF.
- R3: During a read that asserts a select, `rdata` equals `ext_rdata`. At all other times `rdata` is 0xFF.
- R4: A write to 0xD sets timer mode, and a read of 0xD clears it. In timer mode, offsets 0x0–0x3 assert `tmr_cs` in place of `grp_cs[0]`. The timer's offset 3 is write-only. Group 1 is not affected by the mode.
- R5: A write to 0xB sets the interrupt enable. A read of 0xB clears it.
- R6: A rising edge on `src_in[i]` sets pending flag i if the enable is high, and `irq` then rises on the third rising clock edge after the input change. Edges seen while disabled, and all falling edges, set nothing.
- R7: `irq` is high exactly when the enable is high and some pending flag is set. Disabling drops `irq` one cycle later but keeps the flags, so re-enabling raises `irq` again.
- R8: A write to 0xF clears all pending flags. A read of 0xF has no effect.
- R9: After reset the enable is off, timer mode is off, no flag is pending and `irq` is low.
- R10: An access to an unmapped offset (0x8, 0x9, 0xA, 0xC, 0xE) asserts no select, reads back as 0xFF, and changes no state.
- R11: When both strobes are high in the same cycle, the access counts as a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 4 | Byte offset within the window |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| ext_rdata | input | 8 | Read data from the selected port group or timer |
| src_in | input | 2 | Asynchronous interrupt source lines, one per group |
| rdata | output | 8 | Read data to the host |
| grp_cs | output | 2 | Port group chip selects |
| tmr_cs | output | 1 | Interval timer chip select |
| reg_ofs | output | 2 | Register offset inside the selected device |
| irq | output | 1 | Shared interrupt request, active high |

## Verification
The chip selects, `reg_ofs` and `rdata` are combinational from the current access, so the bench checks them in the same cycle the strobe is driven, shortly after the falling edge. The enable, the timer mode and the pending clear take effect at the rising edge that samples the strobe, and they are checked at the next falling edge. A source change needs three rising edges to reach `irq`: two synchroniser flops, then the pending flag. The bench therefore checks that `irq` is still low after two edges and high after the third.

// File: rtl/dio_bus_pkg.sv
package dio_bus_pkg;
   // control offsets, fixed by the host software's expectations
   localparam int unsigned OFS_IRQ_EN   = 11;
   localparam int unsigned OFS_TMR_MODE = 13;
   localparam int unsigned OFS_IRQ_CLR  = 15;
   // each port group spans four bytes, the last one is its write-only control slot
   localparam int unsigned PORT_SPAN    = 4;
   localparam int unsigned CTRL_SLOT    = PORT_SPAN - 1;

   typedef struct packed {
      logic en_set;
      logic en_clr;
      logic mode_set;
      logic mode_clr;
      logic pend_clr;
   } ctl_strb_t;
endpackage

// File: rtl/dio_addr_dec.sv
module dio_addr_dec
   import dio_bus_pkg::*;
#(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned N_GRP  = 2
)(
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic              tmr_mode,
   output logic [N_GRP-1:0]  grp_cs,
   output logic              tmr_cs,
   output logic              data_sel,
   output ctl_strb_t         strb
);
   localparam int unsigned SLOT_W = $clog2(PORT_SPAN);
   localparam int unsigned BLK_W  = ADDR_W - SLOT_W;

   logic             wr_act, rd_act, slot_rd_ok, access;
   logic [BLK_W-1:0] blk;

   // a write wins when both strobes arrive together
   assign wr_act     = wr_en;
   assign rd_act     = rd_en & ~wr_en;
   assign blk        = addr[ADDR_W-1:SLOT_W];
   assign slot_rd_ok = addr[SLOT_W-1:0] != SLOT_W'(CTRL_SLOT);
   assign access     = wr_act | (rd_act & slot_rd_ok);

   generate
      for (genvar g = 0; g < N_GRP; g++) begin : g_grp
         if (g == 0) begin : g_shared
            // the timer borrows the first group's offsets while mode is set
            assign grp_cs[g] = access && (blk == BLK_W'(g)) && !tmr_mode;
         end else begin : g_plain
            assign grp_cs[g] = access && (blk == BLK_W'(g));
         end
      end
   endgenerate

   assign tmr_cs   = access && (blk == '0) && tmr_mode;
   assign data_sel = rd_act && ((|grp_cs) || tmr_cs);

   always_comb begin
      strb.en_set   = wr_act && (addr == ADDR_W'(OFS_IRQ_EN));
      strb.en_clr   = rd_act && (addr == ADDR_W'(OFS_IRQ_EN));
      strb.mode_set = wr_act && (addr == ADDR_W'(OFS_TMR_MODE));
      strb.mode_clr = rd_act && (addr == ADDR_W'(OFS_TMR_MODE));
      strb.pend_clr = wr_act && (addr == ADDR_W'(OFS_IRQ_CLR));
   end
endmodule

// File: rtl/dio_ctl_regs.sv
module dio_ctl_regs
   import dio_bus_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  ctl_strb_t strb,
   output logic      irq_en,
   output logic      tmr_mode
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_en   <= 1'b0;
         tmr_mode <= 1'b0;
      end else begin
         if (strb.en_set)        irq_en <= 1'b1;
         else if (strb.en_clr)   irq_en <= 1'b0;
         if (strb.mode_set)      tmr_mode <= 1'b1;
         else if (strb.mode_clr) tmr_mode <= 1'b0;
      end
   end
endmodule

// File: rtl/dio_edge_sync.sv
module dio_edge_sync #(
   parameter int unsigned N      = 2,
   parameter int unsigned STAGES = 2
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] src_in,
   output logic [N-1:0] rise
);
   generate
      for (genvar b = 0; b < N; b++) begin : g_bit
         // STAGES synchroniser flops plus one history flop for the edge
         logic [STAGES:0] sh;
         always_ff @(posedge clk) begin
            if (!rst_n) sh <= '0;
            else        sh <= {sh[STAGES-1:0], src_in[b]};
         end
         assign rise[b] = sh[STAGES-1] & ~sh[STAGES];
      end
   endgenerate
endmodule

// File: rtl/dio_irq_pend.sv
module dio_irq_pend #(
   parameter int unsigned N = 2
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] rise,
   input  logic         irq_en,
   input  logic         clr,
   output logic [N-1:0] pend,
   output logic         irq
);
   // a new edge in the clearing cycle survives the clear
   always_ff @(posedge clk) begin
      if (!rst_n) pend <= '0;
      else        pend <= (pend & ~{N{clr}}) | (rise & {N{irq_en}});
   end

   assign irq = irq_en & (|pend);
endmodule

// File: rtl/dio_bus_ctrl.sv
module dio_bus_ctrl
   import dio_bus_pkg::*;
#(
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned N_GRP       = 2,
   parameter int unsigned SYNC_STAGES = 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [DATA_W-1:0] ext_rdata,
   input  logic [N_GRP-1:0]  src_in,
   output logic [DATA_W-1:0] rdata,
   output logic [N_GRP-1:0]  grp_cs,
   output logic              tmr_cs,
   output logic [1:0]        reg_ofs,
   output logic              irq
);
   generate
      if (ADDR_W < 4)                     $error("window needs at least 4 address bits");
      if (N_GRP < 1 || N_GRP * PORT_SPAN > 8) $error("port groups must fit below 0x8");
      if (SYNC_STAGES < 2)                $error("at least two synchroniser stages");
      if (DATA_W < 1)                     $error("data width must be positive");
   endgenerate

   ctl_strb_t        strb;
   logic             irq_en_q, tmr_mode_q, data_sel;
   logic [N_GRP-1:0] src_rise, pend_q;

   dio_addr_dec #(.ADDR_W(ADDR_W), .N_GRP(N_GRP)) u_dec (
      .addr(addr), .wr_en(wr_en), .rd_en(rd_en), .tmr_mode(tmr_mode_q),
      .grp_cs(grp_cs), .tmr_cs(tmr_cs), .data_sel(data_sel), .strb(strb)
   );

   dio_ctl_regs u_ctl (
      .clk(clk), .rst_n(rst_n), .strb(strb),
      .irq_en(irq_en_q), .tmr_mode(tmr_mode_q)
   );

   dio_edge_sync #(.N(N_GRP), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .src_in(src_in), .rise(src_rise)
   );

   dio_irq_pend #(.N(N_GRP)) u_pend (
      .clk(clk), .rst_n(rst_n), .rise(src_rise), .irq_en(irq_en_q),
      .clr(strb.pend_clr), .pend(pend_q), .irq(irq)
   );

   assign reg_ofs = addr[1:0];
   assign rdata   = data_sel ? ext_rdata : '1;
endmodule

// File: rtl/dio_bus_ctrl_chk.sv
module dio_bus_ctrl_chk #(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned N_GRP  = 2
)(
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic              wr_en,
   input logic              rd_en,
   input logic [DATA_W-1:0] rdata,
   input logic [N_GRP-1:0]  grp_cs,
   input logic              tmr_cs,
   input logic              irq,
   input logic              irq_en,
   input logic [N_GRP-1:0]  pend,
   input logic [N_GRP-1:0]  rise
);
   // R1
   cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({grp_cs, tmr_cs}));
   // R2
   wo_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !wr_en && addr[1:0] == 2'd3) |-> (rdata == '1 && grp_cs == '0 && !tmr_cs));
   // R10
   unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !wr_en && addr >= ADDR_W'(N_GRP * 4)) |-> (rdata == '1 && grp_cs == '0 && !tmr_cs));
   // R5
   en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(11)) |=> irq_en);
   // R5
   en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !wr_en && addr == ADDR_W'(11)) |=> (!irq_en && !irq));
   // R7
   pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !wr_en && addr == ADDR_W'(11)) |=> ((pend & $past(pend)) == $past(pend)));
   // R6
   rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en && (|rise) && !(rd_en && !wr_en && addr == ADDR_W'(11))) |=> irq);
   // R8
   clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(15) && rise == '0) |=> (pend == '0));
   // R9
   rst_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!irq_en && pend == '0 && !irq));
endmodule

bind dio_bus_ctrl dio_bus_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_GRP(N_GRP)) u_chk (
   .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
   .rdata(rdata), .grp_cs(grp_cs), .tmr_cs(tmr_cs), .irq(irq),
   .irq_en(irq_en_q), .pend(pend_q), .rise(src_rise)
);

// File: tb/sim_dio_bus_ctrl.sv
module sim_dio_bus_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] addr = '0;
   logic       wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0] ext_rdata = 8'h5A;
   logic [1:0] src_in = '0;
   logic [7:0] rdata;
   logic [1:0] grp_cs;
   logic       tmr_cs, irq;
   logic [1:0] reg_ofs;
   int         n_run = 0, n_fail = 0;

   always #10 clk = ~clk;

   dio_bus_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
      .ext_rdata(ext_rdata), .src_in(src_in), .rdata(rdata), .grp_cs(grp_cs),
      .tmr_cs(tmr_cs), .reg_ofs(reg_ofs), .irq(irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // drive an access at the falling edge and let combinational outputs settle
   task automatic drive(input logic [3:0] a, input logic w, input logic r);
      @(negedge clk);
      addr = a; wr_en = w; rd_en = r;
      #2;
   endtask

   task automatic idle();
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
      #2;
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
      #2;
   endtask

   task automatic t_reset();
      chk("R9 irq", irq, 0);
      drive(4'h0, 1, 0);
      chk("R9 mode off grp0", {grp_cs, tmr_cs}, 3'b010);
      idle();
   endtask

   task automatic t_group_decode();
      for (int a = 0; a < 8; a++) begin
         drive(4'(a), 1, 0);
         chk("R1 wr cs", {grp_cs, tmr_cs}, (a < 4) ? 3'b010 : 3'b100);
         chk("R1 ofs", reg_ofs, a % 4);
      end
      drive(4'h5, 0, 1);
      chk("R1 rd grp1", grp_cs, 2'b10);
      chk("R3 rdata", rdata, 8'h5A);
      ext_rdata = 8'hC3;
      drive(4'h1, 0, 1);
      chk("R3 rdata follows", rdata, 8'hC3);
      drive(4'h3, 0, 1);
      chk("R2 cs", {grp_cs, tmr_cs}, 0);
      chk("R2 data", rdata, 8'hFF);
      drive(4'h7, 0, 1);
      chk("R2 cs 7", {grp_cs, tmr_cs}, 0);
      chk("R2 data 7", rdata, 8'hFF);
      drive(4'h2, 0, 0);
      chk("R3 no strobe", rdata, 8'hFF);
      idle();
      ext_rdata = 8'h5A;
   endtask

   task automatic t_timer_mode();
      drive(4'hD, 1, 0); idle();
      drive(4'h0, 1, 0);
      chk("R4 tmr wr", {grp_cs, tmr_cs}, 3'b001);
      drive(4'h2, 0, 1);
      chk("R4 tmr rd", {grp_cs, tmr_cs}, 3'b001);
      chk("R4 tmr data", rdata, 8'h5A);
      drive(4'h3, 0, 1);
      chk("R4 tmr slot3 rd", {grp_cs, tmr_cs, rdata}, {3'b000, 8'hFF});
      drive(4'h3, 1, 0);
      chk("R4 tmr slot3 wr", {grp_cs, tmr_cs}, 3'b001);
      drive(4'h6, 0, 1);
      chk("R4 grp1 kept", {grp_cs, tmr_cs}, 3'b100);
      drive(4'hD, 0, 1); idle();
      drive(4'h0, 1, 0);
      chk("R4 mode cleared", {grp_cs, tmr_cs}, 3'b010);
      idle();
   endtask

   task automatic t_irq_edge();
      drive(4'hB, 1, 0); idle();
      chk("R5 no pend yet", irq, 0);
      @(negedge clk); src_in[0] = 1'b1;
      cyc(2);
      chk("R6 two edges", irq, 0);
      cyc(1);
      chk("R6 third edge", irq, 1);
      @(negedge clk); src_in[0] = 1'b0;
      drive(4'hF, 1, 0); idle();
      chk("R8 cleared", irq, 0);
      cyc(4);
      chk("R6 falling ignored", irq, 0);
      @(negedge clk); src_in[1] = 1'b1;
      cyc(4);
      chk("R6 src1", irq, 1);
      drive(4'hF, 1, 0); idle();
      @(negedge clk); src_in[1] = 1'b0;
      cyc(3);
   endtask

   task automatic t_disable_keep();
      @(negedge clk); src_in[0] = 1'b1;
      cyc(4);
      chk("R7 set", irq, 1);
      drive(4'hB, 0, 1); idle();
      chk("R7 disabled", irq, 0);
      drive(4'hB, 1, 0); idle();
      chk("R7 pend kept", irq, 1);
      drive(4'hB, 0, 1); idle();
      drive(4'hB, 1, 1); idle();
      chk("R11 both strobes write", irq, 1);
      drive(4'hF, 0, 1); idle();
      chk("R8 read no clear", irq, 1);
      drive(4'hF, 1, 0); idle();
      chk("R8 write clear", irq, 0);
      @(negedge clk); src_in[0] = 1'b0;
      cyc(3);
      drive(4'hB, 0, 1); idle();
      @(negedge clk); src_in[1] = 1'b1;
      cyc(5);
      drive(4'hB, 1, 0); idle();
      chk("R6 edge while disabled", irq, 0);
      @(negedge clk); src_in[1] = 1'b0;
      cyc(3);
   endtask

   task automatic t_unmapped();
      logic [3:0] um [5] = '{4'h8, 4'h9, 4'hA, 4'hC, 4'hE};
      @(negedge clk); src_in[0] = 1'b1;
      cyc(4);
      for (int i = 0; i < 5; i++) begin
         drive(um[i], 0, 1);
         chk("R10 rd", {grp_cs, tmr_cs, rdata}, {3'b000, 8'hFF});
         drive(um[i], 1, 0);
         chk("R10 wr cs", {grp_cs, tmr_cs}, 0);
      end
      idle();
      chk("R10 irq unchanged", irq, 1);
      drive(4'h0, 1, 0);
      chk("R10 mode unchanged", {grp_cs, tmr_cs}, 3'b010);
      drive(4'hD, 1, 0); idle();
      drive(4'hD, 1, 1); idle();
      drive(4'h1, 1, 0);
      chk("R11 mode kept", {grp_cs, tmr_cs}, 3'b001);
      drive(4'hD, 0, 1);
      drive(4'hF, 1, 0);
      idle();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_group_decode();
      t_timer_mode();
      t_irq_edge();
      t_disable_keep();
      t_unmapped();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule